// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the timing skeleton of a video raster: horizontal and vertical sync, a data-enable window, a one-cycle start-of-frame pulse and the coordinates of the pixel currently being scanned. Software sets it up through a 32-bit register port. It writes the frame geometry, the sync placement and the blanking lengths, picks the sync polarities and a pixel width, and then sets an enable bit. Fetching pixels from memory, converting colours and generating clocks are left to other blocks. Those blocks use the data-enable and coordinate outputs to decide when to present a pixel.

Every geometry register holds two 16-bit fields, each storing a quantity minus one. The horizontal quantity is in the upper half and the vertical one in the lower half. The frame register holds the total line length and total frame height, blanking included. The blanking register holds the blanking lengths, so the active size is the total minus the blanking. The two sync registers place the start and end of each pulse as offsets past the end of the active region. Geometry, polarity and pixel width go live together, at a frame boundary, through a shadow copy that a start command requests. The design uses a single clock, which serves as both the register clock and the pixel clock.

Top module: `raster_timing_gen`

## Requirements
- R1: During reset, all counters and registers are cleared to their defaults. The default geometry is 800x525 total, 160x45 blanking, hsync at offsets 16..112 and vsync at offsets 10..12. Control and status read 0 after reset, and the outputs show the idle state.
- R2: The register map is at byte offsets 0x10 (frame totals), 0x14 (hsync offsets), 0x18 (vsync offsets), 0x1C (blanking lengths), 0x40 (buffer address) and 0x50 (line stride), and each of these reads back what was written. Control at 0x00 reads back bits 4..1. The start command at 0x84 reads 0, and unmapped offsets read 0.
- R3: Offset 0x3FC always reads the ID_VALUE parameter, and writes to it have no effect.
- R4: While control bit 1 (enable) is clear, x and y are 0, data-enable and start-of-frame are low, and both syncs are at their inactive level.
- R5: The write that sets the enable bit is followed by a cycle that presents pixel (0,0). After that, x increments by one each clock and wraps to 0 after the total-minus-one value, at which point y increments. y wraps to 0 after its own total-minus-one value.
- R6: Data-enable is high exactly when x < (total width − blanking width) and y < (total height − blanking height).
- R7: hsync is asserted while active width + (hsync start field + 1) ≤ x < active width + (hsync end field + 1). The start field is bits 31:16 of 0x14 and the end field is bits 15:0. vsync follows the same rule in y, using 0x18.
- R8: When control bit 4 is set, hsync is active-high; when it is clear, hsync is active-low. Control bit 3 selects the vsync polarity in the same way.
- R9: Start-of-frame is high for exactly the cycle in which enabled scanning is at pixel (0,0).
- R10: Writing 1 to bit 0 of 0x84 requests a shadow copy of the geometry, the polarity bits and the pixel-width bit. The copy happens on the clock edge where the scan wraps from the last pixel of the last line, or on the next edge if the block is disabled. Status bit 1 (busy) reads 1 from the write until that copy.
- R11: Output pix_wide shows the shadowed control bit 2, where 1 means 32-bit pixels and 0 means 16-bit pixels.
- R12: Totals of 2200 pixels and 1125 lines are stored and scanned without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 10 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 10 | Register read byte offset |
| rd_data | output | 32 | Register read data (combinational) |
| hsync | output | 1 | Horizontal sync at programmed polarity |
| vsync | output | 1 | Vertical sync at programmed polarity |
| de | output | 1 | Active-video data enable |
| sof | output | 1 | Start-of-frame pulse |
| px_x | output | 16 | Current pixel column |
| px_y | output | 16 | Current line |
| pix_wide | output | 1 | Live pixel width select (1 = 32-bit) |

## Verification
A counter that slips shows up within one cycle as a wrong px_x. It also moves the data-enable and sync edges for every remaining pixel of the line, so any error in horizontal state is visible immediately. A shadow copy taken at the wrong edge is different: it changes geometry in the middle of a frame, and the resulting misplaced sync or blanking edge may appear only on a later line. The per-cycle reference model compares every output on every cycle across frames in which the geometry changes. The busy bit is compared on every cycle, so a copy taken early or late is caught on the exact cycle where it happens.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
    localparam int FW     = 16;
    localparam int ADDR_W = 10;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_CTRL   = 10'h000;
    localparam logic [ADDR_W-1:0] A_STAT   = 10'h004;
    localparam logic [ADDR_W-1:0] A_FRAME  = 10'h010;
    localparam logic [ADDR_W-1:0] A_HSYNC  = 10'h014;
    localparam logic [ADDR_W-1:0] A_VSYNC  = 10'h018;
    localparam logic [ADDR_W-1:0] A_BLANK  = 10'h01C;
    localparam logic [ADDR_W-1:0] A_BUF    = 10'h040;
    localparam logic [ADDR_W-1:0] A_STRIDE = 10'h050;
    localparam logic [ADDR_W-1:0] A_START  = 10'h084;
    localparam logic [ADDR_W-1:0] A_IDENT  = 10'h3FC;

    localparam int B_EN = 1, B_WIDE = 2, B_VPOL = 3, B_HPOL = 4, B_BUSY = 1;

    typedef struct packed {
        logic [FW-1:0] h;
        logic [FW-1:0] v;
    } pair_t;

    typedef struct packed {
        pair_t frame;
        pair_t hs;
        pair_t vs;
        pair_t blank;
        logic  hs_hi;
        logic  vs_hi;
        logic  wide;
    } dtg_mode_t;

    typedef struct packed {
        logic [FW-1:0] h_last;
        logic [FW-1:0] v_last;
        logic [FW-1:0] act_w;
        logic [FW-1:0] act_h;
        logic [FW:0]   hs_on;
        logic [FW:0]   hs_off;
        logic [FW:0]   vs_on;
        logic [FW:0]   vs_off;
    } dtg_timing_t;

    localparam dtg_mode_t DEF_MODE = '{
        frame: '{h: 16'd799, v: 16'd524},
        hs:    '{h: 16'd15,  v: 16'd111},
        vs:    '{h: 16'd9,   v: 16'd11},
        blank: '{h: 16'd159, v: 16'd44},
        hs_hi: 1'b0, vs_hi: 1'b0, wide: 1'b0};

    function automatic dtg_timing_t decode_mode(input dtg_mode_t m);
        dtg_timing_t t;
        t.h_last = m.frame.h;
        t.v_last = m.frame.v;
        t.act_w  = m.frame.h - m.blank.h;
        t.act_h  = m.frame.v - m.blank.v;
        t.hs_on  = {1'b0, t.act_w} + {1'b0, m.hs.h} + 17'd1;
        t.hs_off = {1'b0, t.act_w} + {1'b0, m.hs.v} + 17'd1;
        t.vs_on  = {1'b0, t.act_h} + {1'b0, m.vs.h} + 17'd1;
        t.vs_off = {1'b0, t.act_h} + {1'b0, m.vs.v} + 17'd1;
        return t;
    endfunction
endpackage

// File: rtl/dtg_regs.sv
module dtg_regs
    import dtg_pkg::*;
#(
    parameter logic [DATA_W-1:0] ID_VALUE = 32'h5D7C_0100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              frame_end,
    output logic              run,
    output logic              run_next,
    output dtg_mode_t         shadow
);
    dtg_mode_t         live_q, shadow_q;
    logic              en_q, pending_q;
    logic [DATA_W-1:0] buf_q, stride_q;
    logic              start_wr, copy;

    assign start_wr = wr_en && (wr_addr == A_START) && wr_data[0];
    assign copy     = pending_q && (!en_q || frame_end);
    assign run_next = (wr_en && wr_addr == A_CTRL) ? wr_data[B_EN] : en_q;
    assign run      = en_q;
    assign shadow   = shadow_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q    <= DEF_MODE;
            shadow_q  <= DEF_MODE;
            en_q      <= 1'b0;
            pending_q <= 1'b0;
            buf_q     <= '0;
            stride_q  <= '0;
        end else begin
            if (copy) shadow_q <= live_q;
            pending_q <= start_wr ? 1'b1 : (copy ? 1'b0 : pending_q);
            if (wr_en) begin
                case (wr_addr)
                    A_CTRL: begin
                        en_q         <= wr_data[B_EN];
                        live_q.wide  <= wr_data[B_WIDE];
                        live_q.vs_hi <= wr_data[B_VPOL];
                        live_q.hs_hi <= wr_data[B_HPOL];
                    end
                    A_FRAME:  live_q.frame <= wr_data;
                    A_HSYNC:  live_q.hs    <= wr_data;
                    A_VSYNC:  live_q.vs    <= wr_data;
                    A_BLANK:  live_q.blank <= wr_data;
                    A_BUF:    buf_q        <= wr_data;
                    A_STRIDE: stride_q     <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (rd_addr)
            A_CTRL:   rd_data = {27'd0, live_q.hs_hi, live_q.vs_hi, live_q.wide, en_q, 1'b0};
            A_STAT:   rd_data = {30'd0, pending_q, 1'b0};
            A_FRAME:  rd_data = live_q.frame;
            A_HSYNC:  rd_data = live_q.hs;
            A_VSYNC:  rd_data = live_q.vs;
            A_BLANK:  rd_data = live_q.blank;
            A_BUF:    rd_data = buf_q;
            A_STRIDE: rd_data = stride_q;
            A_IDENT:  rd_data = ID_VALUE;
            default:  rd_data = '0;
        endcase
    end

    // R10: busy may only drop on an edge where a copy was allowed
    assert_busy_release_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(pending_q) |-> $past(!en_q || frame_end));
    // R10: shadow only changes following a pending request at a legal edge
    assert_shadow_gate_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(shadow_q) |-> $past(pending_q && (!en_q || frame_end)));
endmodule

// File: rtl/dtg_raster.sv
module dtg_raster
    import dtg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          run_next,
    input  dtg_timing_t   tm,
    input  logic          hs_hi,
    input  logic          vs_hi,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic          sof,
    output logic [FW-1:0] px_x,
    output logic [FW-1:0] px_y,
    output logic          frame_end
);
    logic [FW-1:0] h_q, v_q;
    logic          line_end, h_act, v_act;

    assign line_end  = (h_q == tm.h_last);
    assign frame_end = run && line_end && (v_q == tm.v_last);

    always_ff @(posedge clk) begin
        if (rst || !run_next) begin
            h_q <= '0;
            v_q <= '0;
        end else if (run) begin
            if (line_end) begin
                h_q <= '0;
                v_q <= (v_q == tm.v_last) ? '0 : v_q + 1'b1;
            end else begin
                h_q <= h_q + 1'b1;
            end
        end
    end

    assign h_act = run && ({1'b0, h_q} >= tm.hs_on) && ({1'b0, h_q} < tm.hs_off);
    assign v_act = run && ({1'b0, v_q} >= tm.vs_on) && ({1'b0, v_q} < tm.vs_off);
    assign hsync = hs_hi ? h_act : !h_act;
    assign vsync = vs_hi ? v_act : !v_act;
    assign de    = run && (h_q < tm.act_w) && (v_q < tm.act_h);
    assign sof   = run && (h_q == '0) && (v_q == '0);
    assign px_x  = h_q;
    assign px_y  = v_q;

    // R4: idle means counters parked at the origin
    assert_idle_origin_R4: assert property (@(posedge clk) disable iff (rst)
        !run |-> (h_q == '0 && v_q == '0));
    // R12: counters never pass the programmed last position
    assert_no_overflow_R12: assert property (@(posedge clk) disable iff (rst)
        (h_q <= tm.h_last) && (v_q <= tm.v_last));
    // R5: steady scanning advances the column by one
    assert_col_step_R5: assert property (@(posedge clk) disable iff (rst)
        run && $past(run) && ($past(h_q) != $past(tm.h_last)) |-> h_q == $past(h_q) + 1'b1);
    // R9: start-of-frame lasts a single cycle in any line longer than one pixel
    assert_sof_single_R9: assert property (@(posedge clk) disable iff (rst)
        sof && (tm.h_last != '0) |=> !sof);
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import dtg_pkg::*;
#(
    parameter logic [31:0] ID_VALUE = 32'h5D7C_0100
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [9:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [9:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic        hsync,
    output logic        vsync,
    output logic        de,
    output logic        sof,
    output logic [15:0] px_x,
    output logic [15:0] px_y,
    output logic        pix_wide
);
    dtg_mode_t   shadow;
    dtg_timing_t tm;
    logic        run, run_next, frame_end;

    assign tm       = decode_mode(shadow);
    assign pix_wide = shadow.wide;

    dtg_regs #(.ID_VALUE(ID_VALUE)) u_regs (
        .clk, .rst, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
        .frame_end, .run, .run_next, .shadow);

    dtg_raster u_raster (
        .clk, .rst, .run, .run_next, .tm,
        .hs_hi(shadow.hs_hi), .vs_hi(shadow.vs_hi),
        .hsync, .vsync, .de, .sof, .px_x, .px_y, .frame_end);
endmodule

// File: tb/raster_timing_gen_test.sv
`timescale 1ns/1ps
module raster_timing_gen_test;
    localparam logic [31:0] IDV = 32'h5D7C_0100;
    logic clk = 0, rst = 1, wr_en = 0;
    logic [9:0] wr_addr = 0, rd_addr = 10'h004;
    logic [31:0] wr_data = 0, rd_data;
    logic hsync, vsync, de, sof, pix_wide;
    logic [15:0] px_x, px_y;
    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    raster_timing_gen uut (.clk, .rst, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
        .hsync, .vsync, .de, .sof, .px_x, .px_y, .pix_wide);

    // bench model state
    logic [31:0] l_ctrl, l_fmt, l_hs, l_vs, l_bl, s_ctrl, s_fmt, s_hs, s_vs, s_bl;
    bit m_en, pend;
    int mh, mv;

    function automatic logic [31:0] enc(input int a, input int b);
        return {16'(a - 1), 16'(b - 1)};
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        l_ctrl = 0; l_fmt = enc(800, 525); l_hs = enc(16, 112); l_vs = enc(10, 12); l_bl = enc(160, 45);
        s_ctrl = l_ctrl; s_fmt = l_fmt; s_hs = l_hs; s_vs = l_vs; s_bl = l_bl;
        m_en = 0; pend = 0; mh = 0; mv = 0;
    endtask

    task automatic check_outputs();
        int aw, ah, hon, hoff, von, voff;
        bit ha, va;
        aw = int'(s_fmt[31:16]) - int'(s_bl[31:16]);
        ah = int'(s_fmt[15:0]) - int'(s_bl[15:0]);
        hon = aw + int'(s_hs[31:16]) + 1; hoff = aw + int'(s_hs[15:0]) + 1;
        von = ah + int'(s_vs[31:16]) + 1; voff = ah + int'(s_vs[15:0]) + 1;
        ha = m_en && mh >= hon && mh < hoff;
        va = m_en && mv >= von && mv < voff;
        chk("R5 R4 px_x", px_x, mh);
        chk("R5 R4 px_y", px_y, mv);
        chk("R6 R4 de", de, m_en && mh < aw && mv < ah);
        chk("R7 R8 hsync", hsync, s_ctrl[4] ? ha : !ha);
        chk("R7 R8 vsync", vsync, s_ctrl[3] ? va : !va);
        chk("R9 sof", sof, m_en && mh == 0 && mv == 0);
        chk("R10 busy", rd_data[1], pend);
        chk("R11 pix_wide", pix_wide, s_ctrl[2]);
    endtask

    task automatic model_edge(input bit w, input logic [9:0] a, input logic [31:0] d);
        bit new_en, wrap, cp;
        new_en = (w && a == 10'h000) ? d[1] : m_en;
        wrap = m_en && mh == int'(s_fmt[31:16]) && mv == int'(s_fmt[15:0]);
        cp = pend && (!m_en || wrap);
        if (!new_en) begin mh = 0; mv = 0; end
        else if (m_en) begin
            if (mh == int'(s_fmt[31:16])) begin
                mh = 0;
                mv = (mv == int'(s_fmt[15:0])) ? 0 : mv + 1;
            end else mh = mh + 1;
        end
        if (cp) begin
            s_ctrl = l_ctrl; s_fmt = l_fmt; s_hs = l_hs; s_vs = l_vs; s_bl = l_bl; pend = 0;
        end
        if (w) begin
            case (a)
                10'h000: l_ctrl = d;
                10'h010: l_fmt = d;
                10'h014: l_hs = d;
                10'h018: l_vs = d;
                10'h01C: l_bl = d;
                10'h084: if (d[0]) pend = 1;
                default: ;
            endcase
        end
        m_en = new_en;
    endtask

    task automatic step(input bit w, input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        check_outputs();
        wr_en = w; wr_addr = a; wr_data = d;
        @(posedge clk);
        model_edge(w, a, d);
        #1 wr_en = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 10'h000, 0);
    endtask

    // only used while disabled and with no copy pending: model state is static
    task automatic rd_check(input string tag, input logic [9:0] a, input logic [31:0] exp);
        @(negedge clk);
        rd_addr = a;
        #1 chk(tag, rd_data, exp);
        rd_addr = 10'h004;
    endtask

    task automatic prog(input int ht, input int hb, input int hs0, input int hs1,
                        input int vt, input int vb, input int vs0, input int vs1,
                        input logic [2:0] pw, input bit en);
        step(1, 10'h010, enc(ht, vt));
        step(1, 10'h014, enc(hs0, hs1));
        step(1, 10'h018, enc(vs0, vs1));
        step(1, 10'h01C, enc(hb, vb));
        step(1, 10'h000, {27'd0, pw[2], pw[1], pw[0], en, 1'b0});
        step(1, 10'h084, 32'd1);
    endtask

    task automatic rand_prog(input bit en, output int frame_len);
        int ht, hb, h0, vt, vb, v0;
        ht = 8 + int'($urandom % 30); hb = 1 + int'($urandom % (ht - 1));
        h0 = 1 + int'($urandom % hb);
        vt = 5 + int'($urandom % 10); vb = 1 + int'($urandom % (vt - 1));
        v0 = 1 + int'($urandom % vb);
        prog(ht, hb, h0, h0 + 1 + int'($urandom % 3), vt, vb, v0, v0 + 1 + int'($urandom % 2),
             3'($urandom), en);
        frame_len = ht * vt;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int fl, fl2;
        logic [31:0] rv;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst = 0;
        idle(3);                                   // R1 R4 idle outputs after reset
        rd_check("R1 ctrl", 10'h000, 0);
        rd_check("R1 status", 10'h004, 0);
        rd_check("R1 frame", 10'h010, enc(800, 525));
        rd_check("R1 hsync", 10'h014, enc(16, 112));
        rd_check("R1 vsync", 10'h018, enc(10, 12));
        rd_check("R1 blank", 10'h01C, enc(160, 45));
        rd_check("R3 id", 10'h3FC, IDV);
        rd_check("R2 start reads 0", 10'h084, 0);
        rd_check("R2 unmapped", 10'h020, 0);
        rv = $urandom;
        step(1, 10'h040, rv);
        rd_check("R2 buffer", 10'h040, rv);
        rv = $urandom;
        step(1, 10'h050, rv);
        rd_check("R2 stride", 10'h050, rv);
        step(1, 10'h3FC, 32'hFFFF_FFFF);
        rd_check("R3 id after write", 10'h3FC, IDV);
        step(1, 10'h000, 32'h0000_001C);
        rd_check("R2 ctrl readback", 10'h000, 32'h0000_001C);
        step(1, 10'h000, 0);

        for (int g = 0; g < 4; g++) begin
            rand_prog(0, fl);
            idle(2);                               // R10 copy while disabled
            step(1, 10'h000, l_ctrl | 32'h2);      // R5 enable
            idle(fl + fl / 2);
            if (g % 2 == 1) begin
                rand_prog(1, fl2);                 // R10 mid-frame request, waits for wrap
                idle(fl + 2 * fl2);
            end
            step(1, 10'h000, l_ctrl & ~32'h2);     // R4 disable
            idle(4);
        end

        // R12 wide line and tall frame
        prog(2200, 280, 88, 132, 3, 1, 1, 2, 3'b111, 0);
        idle(2);
        rd_check("R12 wide frame readback", 10'h010, enc(2200, 3));
        step(1, 10'h000, l_ctrl | 32'h2);
        idle(2200 * 3 + 10);
        step(1, 10'h000, 0);
        prog(4, 1, 1, 2, 1125, 45, 4, 9, 3'b000, 0);
        idle(2);
        rd_check("R12 tall frame readback", 10'h010, enc(4, 1125));
        step(1, 10'h000, 32'h2);
        idle(4 * 1125 + 10);
        step(1, 10'h000, 0);
        idle(3);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule